// File: doc/BRIEF.md
# Nested Vectored Interrupt Dispatcher

This block takes a vector of interrupt sources that have already passed enable and type masking, and turns them into a single interrupt request plus a vector address that software fetches at the start of its service routine. Sixteen programmable slots each bind one of the 32 sources to a vector address. Slot index gives priority: slot 0 ranks highest and slot 15 lowest. A seventeenth level covers every pending source that no enabled slot claims, and that level is served through a default address.

The block tracks the priority level currently in service. Reading the current-vector register finds the highest-priority pending request that outranks that level, enters it, records the level it interrupted, and returns that level's address. Writing the same register closes the level in service and goes back to the recorded one. While a level is in service, the request output is held back for everything except sources bound to strictly higher-priority enabled slots. With no level in service, the request follows any masked source.

Register access uses a plain single-cycle strobe port (`acc_en` with `acc_wr`). Every access is taken in the cycle it is presented, so there is no back-pressure. Read data comes back one cycle later, marked by `rd_valid`. Byte offsets that the behaviour depends on are: current vector 0x030, default vector 0x034, slot addresses 0x100 + 4·n, and slot controls 0x200 + 4·n. Address bits 1:0 are ignored.

Top module: `vpn_nest_unit`

## Requirements
- R1: After reset, all slot addresses, all slot controls and the default address read zero, no level is in service (idle level 17), and `irq_out` is low.
- R2: In a slot control byte, bit 5 enables the slot and bits 4:0 select its source. A disabled slot never claims its source and never lets it through the request gate.
- R3: `irq_out` equals, one cycle later, the OR of `irq_pend` ANDed with the gate of the level in service. The gate for level L is the set of sources of enabled slots with index below L. Level 16 covers all enabled slots, and the idle level passes every source.
- R4: A read of 0x030 picks the lowest level i below the level in service for which `raw_pend` meets the gate of level i+1. It enters level i and returns that level's address (slot i's address, or the default address when i is 16).
- R5: On entering a level, the interrupted level is recorded against it. A write to 0x030 while a level is in service returns to the recorded level, whatever the data, so entries nested at least three deep unwind in reverse order.
- R6: A read of 0x030 at the idle level returns the default address and leaves the level idle when no raw source is pending. It enters level 16 when the only pending sources are unclaimed.
- R7: A read of 0x030 when nothing outranks the level in service returns that level's address and leaves the level unchanged.
- R8: A write to 0x030 at the idle level has no effect on the level.
- R9: Slot addresses (32 bits), slot controls (8 bits, zero-extended) and the default address read back as written. Any other offset reads zero.
- R10: Every read returns its data on `rd_data` with `rd_valid` high exactly one cycle after the strobe. `rd_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_pend | input | 32 | Raw pending sources (hardware or software), used by the vector scan |
| irq_pend | input | 32 | Pending sources after enable and type masking, used by the request gate |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 32 | Read data |
| irq_out | output | 1 | Gated interrupt request |

## Verification
The hardest state to reach is a stack nested three or more levels deep, where each entry was made while a lower-priority level was already in service. The pending sources must also change between entries, so that the gate, the scan and the unwind all operate on different masks. Directed sequences raise sources one at a time in rising priority, with a vector read after each, and then unwind with writes while clearing sources. Random phases then mix slot reprogramming under an active stack, sparse pending patterns, and reads and writes of the current vector. A bench model of the scan and the saved-level table predicts every returned address and every request level.

// File: rtl/vpn_pkg.sv
package vpn_pkg;

  // Byte offsets whose values the software-visible behaviour depends on
  localparam int unsigned OFS_VEC_CUR   = 32'h030;
  localparam int unsigned OFS_VEC_DEF   = 32'h034;
  localparam int unsigned OFS_SLOT_ADDR = 32'h100;
  localparam int unsigned OFS_SLOT_CTL  = 32'h200;

  // Slot control byte layout
  localparam int unsigned CTL_EN_BIT = 5;
  localparam int unsigned CTL_W      = 8;

  typedef enum logic [2:0] {
    K_NONE,
    K_VEC_CUR,
    K_VEC_DEF,
    K_SLOT_ADDR,
    K_SLOT_CTL
  } acc_kind_e;

endpackage

// File: rtl/vpn_mask_gen.sv
module vpn_mask_gen #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned SRC_W     = 5
) (
  input  logic [NUM_SLOTS-1:0]               slot_en,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0]    slot_src,
  output logic [NUM_SLOTS+1:0][NUM_SRC-1:0]  lvl_mask
);

  logic [NUM_SLOTS-1:0][NUM_SRC-1:0] claim;

  // One-hot source claimed by each enabled slot
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_claim
    assign claim[g] = slot_en[g] ? (NUM_SRC'(1) << slot_src[g]) : '0;
  end

  // Gate of level L = sources of enabled slots ranked above L; idle passes all
  always_comb begin
    lvl_mask[0] = '0;
    for (int i = 1; i <= NUM_SLOTS; i++) begin
      lvl_mask[i] = lvl_mask[i-1] | claim[i-1];
    end
    lvl_mask[NUM_SLOTS+1] = '1;
  end

endmodule

// File: rtl/vpn_scan.sv
module vpn_scan #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned LVL_W     = 5
) (
  input  logic [NUM_SRC-1:0]                 raw_pend,
  input  logic [NUM_SLOTS+1:0][NUM_SRC-1:0]  lvl_mask,
  input  logic [LVL_W-1:0]                   cur_lvl,
  output logic                               found,
  output logic [LVL_W-1:0]                   hit_lvl
);

  logic [NUM_SLOTS:0] hit;

  // Level g wins when it outranks the level in service and a pending
  // source falls inside the gate of the level just below it
  for (genvar g = 0; g <= NUM_SLOTS; g++) begin : g_hit
    assign hit[g] = (LVL_W'(g) < cur_lvl) && (|(raw_pend & lvl_mask[g+1]));
  end

  always_comb begin
    found   = 1'b0;
    hit_lvl = '0;
    for (int i = NUM_SLOTS; i >= 0; i--) begin
      if (hit[i]) begin
        found   = 1'b1;
        hit_lvl = LVL_W'(i);
      end
    end
  end

  logic unused_lvl0;
  assign unused_lvl0 = ^lvl_mask[0];

endmodule

// File: rtl/vpn_level_stack.sv
module vpn_level_stack #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned LVL_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic [LVL_W-1:0] enter_lvl,
  input  logic             leave,
  output logic [LVL_W-1:0] cur_lvl,
  output logic [LVL_W-1:0] prev_of_cur
);

  localparam int unsigned IDLE    = NUM_SLOTS + 1;
  localparam int unsigned ENTRIES = IDLE + 1;

  logic [LVL_W-1:0] cur_q;
  logic [LVL_W-1:0] prev_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= LVL_W'(IDLE);
      for (int i = 0; i < ENTRIES; i++) prev_q[i] <= LVL_W'(IDLE);
    end else if (enter) begin
      prev_q[enter_lvl] <= cur_q;
      cur_q             <= enter_lvl;
    end else if (leave && (cur_q != LVL_W'(IDLE))) begin
      cur_q <= prev_q[cur_q];
    end
  end

  assign cur_lvl     = cur_q;
  assign prev_of_cur = prev_q[cur_q];

endmodule

// File: rtl/vpn_nest_unit.sv
module vpn_nest_unit #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raw_pend,
  input  logic [NUM_SRC-1:0] irq_pend,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [AW-1:0]      acc_addr,
  input  logic [DW-1:0]      acc_wdata,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data,
  output logic               irq_out
);
  import vpn_pkg::*;

  localparam int unsigned SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int unsigned LVL_W  = $clog2(NUM_SLOTS + 2);
  localparam int unsigned IDLE   = NUM_SLOTS + 1;
  localparam logic [AW-1:0] A_BASE = AW'(OFS_SLOT_ADDR);
  localparam logic [AW-1:0] C_BASE = AW'(OFS_SLOT_CTL);
  localparam logic [AW-1:0] WIN    = AW'(4 * NUM_SLOTS);

  // Storage: entry NUM_SLOTS of the address array is the default vector
  logic [DW-1:0]                   vec_q [NUM_SLOTS+1];
  logic [NUM_SLOTS-1:0][CTL_W-1:0] ctl_q;

  // Address decode
  acc_kind_e        kind;
  logic [AW-1:0]    off_a, off_c;
  logic [SLOT_W-1:0] sel_a, sel_c;

  assign off_a = acc_addr - A_BASE;
  assign off_c = acc_addr - C_BASE;
  assign sel_a = off_a[SLOT_W+1:2];
  assign sel_c = off_c[SLOT_W+1:2];

  always_comb begin
    kind = K_NONE;
    if (acc_addr[AW-1:2] == AW'(OFS_VEC_CUR) >> 2)      kind = K_VEC_CUR;
    else if (acc_addr[AW-1:2] == AW'(OFS_VEC_DEF) >> 2) kind = K_VEC_DEF;
    else if (acc_addr >= A_BASE && acc_addr < A_BASE + WIN) kind = K_SLOT_ADDR;
    else if (acc_addr >= C_BASE && acc_addr < C_BASE + WIN) kind = K_SLOT_CTL;
  end

  // Slot fields
  logic [NUM_SLOTS-1:0]            slot_en;
  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_fields
    assign slot_en[g]  = ctl_q[g][CTL_EN_BIT];
    assign slot_src[g] = ctl_q[g][SRC_W-1:0];
  end

  logic [NUM_SLOTS+1:0][NUM_SRC-1:0] lvl_mask;

  vpn_mask_gen #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W)
  ) u_mask (
    .slot_en  (slot_en),
    .slot_src (slot_src),
    .lvl_mask (lvl_mask)
  );

  logic [LVL_W-1:0] cur_lvl, prev_of_cur, hit_lvl;
  logic             found;

  vpn_scan #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .LVL_W(LVL_W)
  ) u_scan (
    .raw_pend (raw_pend),
    .lvl_mask (lvl_mask),
    .cur_lvl  (cur_lvl),
    .found    (found),
    .hit_lvl  (hit_lvl)
  );

  logic is_vec_cur, enter, leave;
  assign is_vec_cur = (kind == K_VEC_CUR);
  assign enter      = acc_en && !acc_wr && is_vec_cur && found;
  assign leave      = acc_en &&  acc_wr && is_vec_cur;

  vpn_level_stack #(
    .NUM_SLOTS(NUM_SLOTS), .LVL_W(LVL_W)
  ) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter       (enter),
    .enter_lvl   (hit_lvl),
    .leave       (leave),
    .cur_lvl     (cur_lvl),
    .prev_of_cur (prev_of_cur)
  );

  // Address returned by a current-vector read
  logic [LVL_W-1:0] ret_idx;
  always_comb begin
    if (found)                        ret_idx = hit_lvl;
    else if (cur_lvl == LVL_W'(IDLE)) ret_idx = LVL_W'(NUM_SLOTS);
    else                              ret_idx = cur_lvl;
  end

  // Register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= NUM_SLOTS; i++) vec_q[i] <= '0;
      ctl_q <= '0;
    end else if (acc_en && acc_wr) begin
      case (kind)
        K_VEC_DEF:   vec_q[NUM_SLOTS] <= acc_wdata;
        K_SLOT_ADDR: vec_q[sel_a]     <= acc_wdata;
        K_SLOT_CTL:  ctl_q[sel_c]     <= acc_wdata[CTL_W-1:0];
        default: ;
      endcase
    end
  end

  // Read path
  logic [DW-1:0] rd_nxt;
  always_comb begin
    case (kind)
      K_VEC_CUR:   rd_nxt = vec_q[ret_idx];
      K_VEC_DEF:   rd_nxt = vec_q[NUM_SLOTS];
      K_SLOT_ADDR: rd_nxt = vec_q[sel_a];
      K_SLOT_CTL:  rd_nxt = DW'(ctl_q[sel_c]);
      default:     rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      irq_out  <= 1'b0;
    end else begin
      rd_valid <= acc_en && !acc_wr;
      if (acc_en && !acc_wr) rd_data <= rd_nxt;
      irq_out  <= |(irq_pend & lvl_mask[cur_lvl]);
    end
  end

  logic unused_bits;
  assign unused_bits = ^{off_a, off_c, acc_addr[1:0], ctl_q};

endmodule

// File: rtl/vpn_nest_chk.sv
module vpn_nest_chk #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned LVL_W     = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_en,
  input logic               acc_wr,
  input logic               is_vec_cur,
  input logic [NUM_SRC-1:0] irq_pend,
  input logic               irq_out,
  input logic               rd_valid,
  input logic [LVL_W-1:0]   cur_lvl,
  input logic [LVL_W-1:0]   prev_of_cur
);
  localparam logic [LVL_W-1:0] IDLE = LVL_W'(NUM_SLOTS + 1);

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend == '0) |=> !irq_out);

  p_idle_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == IDLE && irq_pend != '0) |=> irq_out);

  p_read_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && is_vec_cur) |=> (cur_lvl <= $past(cur_lvl)));

  p_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && is_vec_cur && cur_lvl != IDLE) |=> (cur_lvl == $past(prev_of_cur)));

  p_level_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lvl <= IDLE);

  p_idle_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && is_vec_cur && cur_lvl == IDLE) |=> (cur_lvl == IDLE));

  p_other_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && is_vec_cur) |=> $stable(cur_lvl));

  p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(acc_en && !acc_wr));

endmodule

bind vpn_nest_unit vpn_nest_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .LVL_W(LVL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_en      (acc_en),
  .acc_wr      (acc_wr),
  .is_vec_cur  (is_vec_cur),
  .irq_pend    (irq_pend),
  .irq_out     (irq_out),
  .rd_valid    (rd_valid),
  .cur_lvl     (cur_lvl),
  .prev_of_cur (prev_of_cur)
);

// File: tb/vpn_nest_unit_bench.sv
`timescale 1ns/1ps
module vpn_nest_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] raw_pend = '0, irq_pend = '0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid, irq_out;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  vpn_nest_unit u_vpn_nest_unit (
    .clk(clk), .rst_n(rst_n), .raw_pend(raw_pend), .irq_pend(irq_pend),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_out(irq_out)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Reference model
  logic [31:0] m_vec [17];
  logic [7:0]  m_ctl [16];
  int          m_cur;
  int          m_prev [18];

  function automatic logic [31:0] gate(int lvl);
    logic [31:0] m = '0;
    if (lvl >= 17) return '1;
    for (int g = 0; g < lvl; g++)
      if (m_ctl[g][5]) m |= 32'd1 << m_ctl[g][4:0];
    return m;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
    if (a == 12'h034) m_vec[16] = d;
    else if (a >= 12'h100 && a < 12'h140) m_vec[(a - 12'h100) >> 2] = d;
    else if (a >= 12'h200 && a < 12'h240) m_ctl[(a - 12'h200) >> 2] = d[7:0];
    else if (a == 12'h030 && m_cur < 17) m_cur = m_prev[m_cur];
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, input string req);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_addr = a;
    @(negedge clk);
    chk(rd_valid === 1'b1, "R10 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
    acc_en = 0;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R10 rd_valid low", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic rd_vec(string req);
    logic [31:0] d, exp;
    int i;
    for (i = 0; i < m_cur; i++) if ((raw_pend & gate(i + 1)) != 0) break;
    if (i < m_cur) begin
      m_prev[i] = m_cur; m_cur = i; exp = m_vec[m_cur];
    end else exp = (m_cur == 17) ? m_vec[16] : m_vec[m_cur];
    rd(12'h030, d, req);
    chk(d === exp, req, d, exp);
  endtask

  task automatic chk_reg(logic [11:0] a, logic [31:0] exp, string req);
    logic [31:0] d;
    rd(a, d, req);
    chk(d === exp, req, d, exp);
  endtask

  task automatic chk_irq(string req);
    logic e;
    @(negedge clk);
    @(negedge clk);
    e = |(irq_pend & gate(m_cur));
    chk(irq_out === e, req, {31'd0, irq_out}, {31'd0, e});
  endtask

  task automatic pend(logic [31:0] r, logic [31:0] q);
    @(negedge clk);
    raw_pend = r; irq_pend = q;
  endtask

  initial begin
    for (int i = 0; i < 17; i++) m_vec[i] = '0;
    for (int i = 0; i < 16; i++) m_ctl[i] = '0;
    for (int i = 0; i < 18; i++) m_prev[i] = 17;
    m_cur = 17;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(irq_out === 1'b0, "R1 irq after reset", {31'd0, irq_out}, 0);
    chk_reg(12'h100, 0, "R1 slot0 addr");
    chk_reg(12'h23C, 0, "R1 slot15 ctl");
    chk_reg(12'h034, 0, "R1 default addr");
    rd_vec("R6 idle read no pending");

    // Programming: slots 0..2 enabled on sources 3,7,12; slot3 disabled on 20
    for (int s = 0; s < 16; s++) wr(12'(12'h100 + 4 * s), 32'h1000 + 32'(s) * 16);
    wr(12'h034, 32'hDEF0);
    wr(12'h200, 32'h23); wr(12'h204, 32'h27); wr(12'h208, 32'h2C); wr(12'h20C, 32'h14);
    chk_reg(12'h104, 32'h1010, "R9 slot1 addr");
    chk_reg(12'h208, 32'h2C, "R9 slot2 ctl");
    chk_reg(12'h034, 32'hDEF0, "R9 default");
    chk_reg(12'h0F0, 0, "R9 unmapped");
    chk_reg(12'h20E, 32'h14, "R9 ignores low addr bits");

    // Nested entry across three levels (R3 R4 R5 R7)
    pend(32'h1000, 32'h1000); chk_irq("R3 idle passes");
    rd_vec("R4 enter slot2");   chk_irq("R3 slot2 gates own source");
    pend(32'h1080, 32'h1080); chk_irq("R3 higher source passes");
    rd_vec("R4 enter slot1");
    pend(32'h1088, 32'h1088); rd_vec("R4 enter slot0");
    chk_irq("R3 level0 blocks all");
    rd_vec("R7 nothing higher");
    pend(32'h1080, 32'h1080); wr(12'h030, 32'hFFFF); chk_irq("R5 back to slot1");
    pend(32'h1000, 32'h1000); wr(12'h030, 0); chk_irq("R5 back to slot2");
    wr(12'h030, 0); chk_irq("R5 back to idle");
    pend(0, 0); wr(12'h030, 32'h5); rd_vec("R8 idle write ignored");

    // Disabled slot and unclaimed source (R2 R6)
    pend(32'h0010_0000, 32'h0010_0000);
    rd_vec("R6 unclaimed enters level16");
    chk_irq("R2 disabled slot not in gate");
    wr(12'h030, 0); chk_irq("R5 leave level16");

    // Random phase
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0: wr(12'(12'h200 + 4 * $urandom_range(0, 15)),
              {24'd0, 2'b00, 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31))});
        1: wr(12'(12'h100 + 4 * $urandom_range(0, 15)), $urandom);
        2, 3: pend($urandom & $urandom & $urandom, $urandom & $urandom & $urandom);
        4, 5, 6: rd_vec("R4 random read");
        7, 8: wr(12'h030, $urandom);
        default: begin
          int s = $urandom_range(0, 15);
          chk_reg(12'(12'h200 + 4 * s), {24'd0, m_ctl[s]}, "R9 random ctl");
        end
      endcase
      chk_irq("R3 random gate");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule